// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the control and status word of a floating-point unit as one 32-bit register. The word carries the rounding mode, a flush-to-zero control, trap enables, sticky exception flags, per-operation cause bits, and up to eight comparison condition codes. The execution datapath reaches it through four paths:
- a full-word write port and a combinational read port;
- a compare-result port that sets or clears a single condition code;
- an exception-report port that delivers the events raised by one operation;
- an issue strobe.

Condition codes are not packed together. Code 0 lives at bit 23. Codes 1 to 7 live at bits 25 to 31. Bit 24 between them is the flush-to-zero control.

On every instruction issue the block keeps two copies of code 0. The "current" copy takes the value of bit 23. The "previous" copy takes the value the current copy held before that issue. A branch that must see the condition as it stood one instruction earlier can use the previous copy. The block drives the active rounding mode to the arithmetic units. It also raises a trap request whenever an enabled exception, or an unimplemented operation, is recorded in the cause field.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the read word is 0, the rounding mode output is 0, the trap request is low and both code-0 copies are 0.
- R2: A register write stores the following fields from the written word:
  - rounding mode at bits 1:0;
  - flags at bits 6:2;
  - enables at bits 11:7;
  - cause at bits 17:12;
  - code 0 at bit 23;
  - flush-to-zero at bit 24;
  - codes 1..7 at bits 25..31.

  Bits 22:18 read as zero and ignore writes.
- R3: The rounding mode output always equals bits 1:0 of the register. The encoding is 0 nearest, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R4: A compare-result update with select n writes its value to bit 23 when n is 0, and to bit 24+n otherwise. Every other bit is unchanged. Bit 24 is never touched by this port.
- R5: An exception report replaces the cause field with the event vector. Event bit i is: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid, 5 unimplemented, and it maps to register bit 12+i. Events 0 to 4 are also ORed into the flag bits at 2+i. Flags stay set until a register write clears them.
- R6: The trap request is high exactly when some cause bit i (i from 0 to 4) and enable bit 7+i are both set, or when the unimplemented cause bit 17 is set.
- R7: On an issue strobe, the previous copy takes the old current copy and the current copy takes bit 23 as it stood before that clock edge. Without a strobe both copies hold.
- R8: When a register write coincides with a compare-result update or an exception report, the written word wins in every field.
- R9: A compare-result update and an exception report in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Full-word register write strobe |
| wr_data_i | input | 32 | Word to write |
| rd_data_o | output | 32 | Current register word |
| cc_we_i | input | 1 | Compare-result update strobe |
| cc_sel_i | input | 3 | Condition code to update |
| cc_val_i | input | 1 | Compare result value |
| exc_valid_i | input | 1 | Exception report strobe |
| exc_evt_i | input | 6 | Event vector, bit i = event i |
| issue_i | input | 1 | Instruction issue strobe |
| rmode_o | output | 2 | Active rounding mode |
| trap_o | output | 1 | Trap request |
| cc0_cur_o | output | 1 | Code 0 sampled at the latest issue |
| cc0_prev_o | output | 1 | Code 0 sampled at the issue before that |

## Verification
Several properties are checked by assertions on every cycle:
- the trap request against the enable and cause fields visible on the read port;
- the stickiness of the flags;
- the cause field after a report;
- a lone compare update leaving every unselected bit alone;
- the issue-time sampling of bit 23 into the code-0 copies;
- a write dominating all other ports.

Other behaviours appear only in the bench's scenarios against its reference model. These are the exact placement of the split condition-code field, the reserved hole reading zero after an all-ones write, the flush-to-zero bit surviving a code-7 update, and the way reports merge with same-cycle compare updates.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int unsigned CSR_W     = 32;
  localparam int unsigned RM_W      = 2;
  localparam int unsigned N_IEEE    = 5;
  localparam int unsigned N_EVT     = 6;
  localparam int unsigned FLAG_LSB  = 2;
  localparam int unsigned EN_LSB    = 7;
  localparam int unsigned CAUSE_LSB = 12;
  localparam int unsigned CC0_POS   = 23;
  localparam int unsigned FTZ_POS   = 24;
  localparam int unsigned CCN_BASE  = 24;
  localparam int unsigned MAX_CC    = 8;
  localparam int unsigned CC_SEL_W  = 3;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_PINF    = 2'd2,
    RM_NINF    = 2'd3
  } rmode_e;

  // register bit holding condition code n; code 0 sits below the ftz bit
  function automatic int unsigned cc_pos(int unsigned n);
    return (n == 0) ? CC0_POS : CCN_BASE + n;
  endfunction

  function automatic logic [CSR_W-1:0] cc_onehot(logic [CC_SEL_W-1:0] n);
    logic [CSR_W-1:0] m;
    m = '0;
    m[cc_pos(int'(n))] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpcsr_ctl_reg.sv
module fpcsr_ctl_reg
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RM_W-1:0]   wr_rm_i,
  input  logic [N_IEEE-1:0] wr_ena_i,
  input  logic              wr_ftz_i,
  output rmode_e            rm_o,
  output logic [N_IEEE-1:0] ena_o,
  output logic              ftz_o
);
  rmode_e            rm_q;
  logic [N_IEEE-1:0] ena_q;
  logic              ftz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rm_q  <= RM_NEAREST;
      ena_q <= '0;
      ftz_q <= 1'b0;
    end else if (wr_en_i) begin
      rm_q  <= rmode_e'(wr_rm_i);
      ena_q <= wr_ena_i;
      ftz_q <= wr_ftz_i;
    end
  end

  assign rm_o  = rm_q;
  assign ena_o = ena_q;
  assign ftz_o = ftz_q;

  // R2
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ena_o) && $stable(ftz_o) && $stable(rm_o));
endmodule

// File: rtl/fpcsr_exc_state.sv
module fpcsr_exc_state
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [N_IEEE-1:0] wr_flags_i,
  input  logic [N_EVT-1:0]  wr_cause_i,
  input  logic              rep_valid_i,
  input  logic [N_EVT-1:0]  rep_evt_i,
  input  logic [N_IEEE-1:0] ena_i,
  output logic [N_IEEE-1:0] flags_o,
  output logic [N_EVT-1:0]  cause_o,
  output logic              trap_o
);
  localparam int unsigned UNIMPL = N_EVT - 1;

  logic [N_IEEE-1:0] flags_q;
  logic [N_EVT-1:0]  cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      cause_q <= '0;
    end else if (wr_en_i) begin
      flags_q <= wr_flags_i;
      cause_q <= wr_cause_i;
    end else if (rep_valid_i) begin
      flags_q <= flags_q | rep_evt_i[N_IEEE-1:0];
      cause_q <= rep_evt_i;
    end
  end

  // unimplemented cause traps regardless of enables
  assign trap_o  = (|(cause_q[N_IEEE-1:0] & ena_i)) | cause_q[UNIMPL];
  assign flags_o = flags_q;
  assign cause_o = cause_q;

  // R5
  flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (flags_o & $past(flags_o)) == $past(flags_o));

  // R5
  cause_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_i && !wr_en_i |=> cause_o == $past(rep_evt_i));
endmodule

// File: rtl/fpcsr_cc_bank.sv
module fpcsr_cc_bank
  import fpcsr_pkg::*;
#(
  parameter int unsigned NUM_CC = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_CC-1:0]   wr_cc_i,
  input  logic                upd_en_i,
  input  logic [CC_SEL_W-1:0] upd_sel_i,
  input  logic                upd_val_i,
  input  logic                issue_i,
  output logic [NUM_CC-1:0]   cc_o,
  output logic                cc0_cur_o,
  output logic                cc0_prev_o
);
  logic [NUM_CC-1:0] cc_q;
  logic              cur_q, prev_q;

  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       cc_q[g] <= 1'b0;
      else if (wr_en_i)                                  cc_q[g] <= wr_cc_i[g];
      else if (upd_en_i && upd_sel_i == CC_SEL_W'(g))    cc_q[g] <= upd_val_i;
    end
  end

  // issue-time sampling uses code 0 as it stood before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (issue_i) begin
      prev_q <= cur_q;
      cur_q  <= cc_q[0];
    end
  end

  assign cc_o       = cc_q;
  assign cc0_cur_o  = cur_q;
  assign cc0_prev_o = prev_q;

  // R4
  cc_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $countones(cc_o ^ $past(cc_o)) <= 1);
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int unsigned NUM_CC = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CSR_W-1:0]    wr_data_i,
  output logic [CSR_W-1:0]    rd_data_o,
  input  logic                cc_we_i,
  input  logic [CC_SEL_W-1:0] cc_sel_i,
  input  logic                cc_val_i,
  input  logic                exc_valid_i,
  input  logic [N_EVT-1:0]    exc_evt_i,
  input  logic                issue_i,
  output logic [RM_W-1:0]     rmode_o,
  output logic                trap_o,
  output logic                cc0_cur_o,
  output logic                cc0_prev_o
);
  localparam int unsigned HOLE_LSB = CAUSE_LSB + N_EVT;

  function automatic logic [CSR_W-1:0] live_mask();
    logic [CSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < HOLE_LSB; i++) m[i] = 1'b1;
    m[FTZ_POS] = 1'b1;
    for (int n = 0; n < int'(NUM_CC); n++) m[cc_pos(n)] = 1'b1;
    return m;
  endfunction
  localparam logic [CSR_W-1:0] LIVE = live_mask();

  rmode_e            rm;
  logic [N_IEEE-1:0] ena, flags;
  logic [N_EVT-1:0]  cause;
  logic              ftz;
  logic [NUM_CC-1:0] cc, wr_cc;
  logic              wr_unused_bits;

  assign wr_unused_bits = ^wr_data_i[CC0_POS-1:HOLE_LSB];

  always_comb begin
    for (int n = 0; n < int'(NUM_CC); n++) wr_cc[n] = wr_data_i[cc_pos(n)];
  end

  fpcsr_ctl_reg u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_rm_i  (wr_data_i[RM_W-1:0]),
    .wr_ena_i (wr_data_i[EN_LSB +: N_IEEE]),
    .wr_ftz_i (wr_data_i[FTZ_POS]),
    .rm_o     (rm),
    .ena_o    (ena),
    .ftz_o    (ftz)
  );

  fpcsr_exc_state u_exc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_flags_i  (wr_data_i[FLAG_LSB +: N_IEEE]),
    .wr_cause_i  (wr_data_i[CAUSE_LSB +: N_EVT]),
    .rep_valid_i (exc_valid_i),
    .rep_evt_i   (exc_evt_i),
    .ena_i       (ena),
    .flags_o     (flags),
    .cause_o     (cause),
    .trap_o      (trap_o)
  );

  fpcsr_cc_bank #(.NUM_CC(NUM_CC)) u_cc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_cc_i    (wr_cc),
    .upd_en_i   (cc_we_i),
    .upd_sel_i  (cc_sel_i),
    .upd_val_i  (cc_val_i),
    .issue_i    (issue_i),
    .cc_o       (cc),
    .cc0_cur_o  (cc0_cur_o),
    .cc0_prev_o (cc0_prev_o)
  );

  always_comb begin
    rd_data_o = '0;
    rd_data_o[RM_W-1:0]           = rm;
    rd_data_o[FLAG_LSB +: N_IEEE] = flags;
    rd_data_o[EN_LSB +: N_IEEE]   = ena;
    rd_data_o[CAUSE_LSB +: N_EVT] = cause;
    rd_data_o[FTZ_POS]            = ftz;
    for (int n = 0; n < int'(NUM_CC); n++) rd_data_o[cc_pos(n)] = cc[n];
  end

  assign rmode_o = rm;

  // R8
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == ($past(wr_data_i) & LIVE));

  // R4
  cc_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_we_i && !wr_en_i && !exc_valid_i |=>
      ((rd_data_o ^ $past(rd_data_o)) & ~cc_onehot($past(cc_sel_i))) == '0);

  // R6
  trap_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == ((|(rd_data_o[CAUSE_LSB +: N_IEEE] & rd_data_o[EN_LSB +: N_IEEE]))
               | rd_data_o[CAUSE_LSB + N_EVT - 1]));

  // R7
  issue_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> cc0_cur_o == $past(rd_data_o[CC0_POS]) && cc0_prev_o == $past(cc0_cur_o));

  // R7
  issue_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(cc0_cur_o) && $stable(cc0_prev_o));

  // R2
  hole_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[CC0_POS-1:HOLE_LSB] == '0);
endmodule

// File: tb/fpcsr_unit_test.sv
`timescale 1ns/1ps
module fpcsr_unit_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, cc_we = 0, cc_val = 0, exc_v = 0, issue = 0;
  logic [31:0] wr_data = 0;
  logic [2:0]  cc_sel = 0;
  logic [5:0]  evt = 0;
  logic [31:0] rd_data;
  logic [1:0]  rmode;
  logic        trap, cur, prev;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_rm, m_flags, m_en, m_cause, m_ftz, m_cur, m_prev;
  int m_cc[8];

  always #10 clk = ~clk;

  fpcsr_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .cc_we_i(cc_we), .cc_sel_i(cc_sel), .cc_val_i(cc_val),
    .exc_valid_i(exc_v), .exc_evt_i(evt), .issue_i(issue),
    .rmode_o(rmode), .trap_o(trap), .cc0_cur_o(cur), .cc0_prev_o(prev)
  );

  function automatic int bitpos(int n);
    return (n == 0) ? 23 : 24 + n;
  endfunction

  function automatic logic [31:0] m_word();
    logic [31:0] w = 0;
    w[1:0]   = m_rm[1:0];
    w[6:2]   = m_flags[4:0];
    w[11:7]  = m_en[4:0];
    w[17:12] = m_cause[5:0];
    w[24]    = m_ftz[0];
    for (int n = 0; n < 8; n++) w[bitpos(n)] = m_cc[n][0];
    return w;
  endfunction

  function automatic logic m_trap();
    logic t = m_cause[5];
    for (int i = 0; i < 5; i++) if (m_cause[i] && m_en[i]) t = 1'b1;
    return t;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rm = 0; m_flags = 0; m_en = 0; m_cause = 0; m_ftz = 0; m_cur = 0; m_prev = 0;
    for (int n = 0; n < 8; n++) m_cc[n] = 0;
  endtask

  // one clock: model follows inputs at posedge, compare at negedge
  task automatic step();
    string tag;
    @(posedge clk);
    if (wr_en && (cc_we || exc_v)) tag = "R8";
    else if (cc_we && exc_v)       tag = "R9";
    else if (cc_we)                tag = "R4";
    else if (exc_v)                tag = "R5";
    else                           tag = "R2";
    if (issue) begin
      m_prev = m_cur;
      m_cur  = m_cc[0];
    end
    if (wr_en) begin
      m_rm = wr_data[1:0]; m_flags = wr_data[6:2]; m_en = wr_data[11:7];
      m_cause = wr_data[17:12]; m_ftz = wr_data[24];
      for (int n = 0; n < 8; n++) m_cc[n] = wr_data[bitpos(n)];
    end else begin
      if (cc_we) m_cc[cc_sel] = cc_val;
      if (exc_v) begin
        m_cause = evt;
        m_flags = m_flags | evt[4:0];
      end
    end
    @(negedge clk);
    chk(tag, rd_data, m_word());
    chk("R3", 32'(rmode), 32'(m_rm));
    chk("R6", 32'(trap), 32'(m_trap()));
    chk("R7", {cur, prev}, {m_cur[0], m_prev[0]});
    wr_en = 0; cc_we = 0; exc_v = 0; issue = 0;
  endtask

  task automatic do_wr(logic [31:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  task automatic do_cc(int n, logic v);
    cc_we = 1; cc_sel = 3'(n); cc_val = v; step();
  endtask

  task automatic do_exc(logic [5:0] e);
    exc_v = 1; evt = e; step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", rd_data, 32'h0);
    chk("R1", {30'd0, rmode}, 32'h0);
    chk("R1", {29'd0, trap, cur, prev}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 all-ones write leaves hole 22:18 at zero
    do_wr(32'hFFFF_FFFF);
    chk("R2", rd_data, 32'hFF83_FFFF);
    do_wr(32'h0);
    // R3 every rounding mode
    for (int r = 0; r < 4; r++) begin
      do_wr(32'(r));
      chk("R3", 32'(rmode), 32'(r));
    end
    do_wr(32'h0);
    // R4 each code in isolation, ftz bit 24 untouched
    for (int n = 0; n < 8; n++) begin
      do_cc(n, 1'b1);
      chk("R4", rd_data, 32'(1) << bitpos(n));
      do_cc(n, 1'b0);
    end
    do_wr(32'h0100_0000);
    do_cc(7, 1'b1);
    chk("R4", rd_data, 32'h8100_0000);
    do_cc(1, 1'b1);
    chk("R4", rd_data, 32'h8300_0000);
    do_wr(32'h0);
    // R5 cause replaced, flags sticky
    do_exc(6'b000101);
    chk("R5", rd_data, 32'h0000_5014);
    do_exc(6'b000010);
    chk("R5", rd_data, 32'h0000_201C);
    // R6 unimplemented traps with enables clear
    do_exc(6'b100000);
    chk("R6", 32'(trap), 32'd1);
    do_exc(6'b001000);
    chk("R6", 32'(trap), 32'd0);
    do_wr(32'h0000_0400);
    do_exc(6'b001000);
    chk("R6", 32'(trap), 32'd1);
    // R7 issue tracking
    do_wr(32'h0);
    do_cc(0, 1'b1);
    issue = 1; step();
    chk("R7", {cur, prev}, 2'b10);
    do_cc(0, 1'b0);
    issue = 1; cc_we = 1; cc_sel = 0; cc_val = 1; step();
    chk("R7", {cur, prev}, 2'b01);
    issue = 1; step();
    chk("R7", {cur, prev}, 2'b10);
    // R8 write beats update and report
    wr_en = 1; wr_data = 32'h0000_0003; cc_we = 1; cc_sel = 2; cc_val = 1;
    exc_v = 1; evt = 6'h3F; step();
    chk("R8", rd_data, 32'h0000_0003);
    // R9 update and report merge
    cc_we = 1; cc_sel = 3; cc_val = 1; exc_v = 1; evt = 6'b010000; step();
    chk("R9", rd_data, 32'h0801_0043);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      wr_en   = ($urandom_range(0, 15) == 0);
      wr_data = $urandom();
      cc_we   = $urandom_range(0, 1);
      cc_sel  = 3'($urandom_range(0, 7));
      cc_val  = $urandom_range(0, 1);
      exc_v   = ($urandom_range(0, 3) == 0);
      evt     = 6'($urandom_range(0, 63));
      issue   = $urandom_range(0, 1);
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule